// File: doc/BRIEF.md
# Double-Buffered Serial Master Shifter

This block is the master end of a three-wire synchronous serial link: it generates the serial clock, shifts one character out on the master-out line and, on the same clock edges, shifts one character in from the master-in line. A host queues characters through a valid/ready write port backed by a one-entry holding buffer. It collects received characters from a valid/ready read port backed by a one-entry receive buffer. The holding buffer frees as soon as its character enters the shift engine, so the next character can be queued while the current one is on the wire. Characters queued in time follow each other with no idle clock.

Writing a character is the only way to start the serial clock, and each character written yields exactly one character read. The character length is 8 bits or 7 bits, chosen by a control pin that is sampled when a character enters the shift engine. A 7-bit character is stored right-justified in the receive buffer. When a character completes while the previous one is still unread, the new one overwrites it and a sticky overrun flag is raised.

Back-pressure rules. On the write side, a character is taken on a cycle with `tx_valid` and `tx_ready` both high. On the read side, a character is consumed on a cycle with `rx_valid` and `rx_ready` both high. The receive side cannot stall the serial link. If the host holds `rx_ready` low while `rx_valid` is high, the next completed character replaces the buffered one and sets `overrun`.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, `tx_ready`=1, `rx_valid`=0, `overrun`=0, `busy`=0, `sclk`=0 and `mosi`=0.
- R2: `tx_ready` is 0 from the cycle after a write is accepted until the buffered character enters the shift engine. That move happens on the first clock edge at which the engine is free and `master_en`=1. `tx_ready` returns to 1 while that character is still shifting.
- R3: While a character is shifting, `sclk` has a period of DIV system clocks (DIV even, at least 2). Each bit period starts with DIV/2 cycles low followed by DIV/2 cycles high. `sclk` is 0 whenever `busy`=0.
- R4: `mosi` carries the character most-significant bit first. Each bit is driven at the start of its bit period, stays stable while `sclk` is high, and `mosi` is 0 when idle.
- R5: `miso` is sampled on the system clock edge at which `sclk` rises, in the middle of each bit period.
- R6: With `len8`=1 a character is 8 bits (`tx_data[7:0]`). With `len8`=0 it is 7 bits, sending `tx_data[6:0]` with bit 6 first. `len8` is sampled when the character enters the shift engine, and later changes do not affect that character.
- R7: One clock edge after the last bit period ends, `rx_valid` is 1 and `rx_data` holds the received character right-justified. For a 7-bit character, `rx_data[7]` is 0.
- R8: A cycle with `rx_valid` and `rx_ready` both high consumes the character, and `rx_valid` falls unless a new character completes in that same cycle.
- R9: If a character completes while `rx_valid`=1 and `rx_ready`=0, `overrun` becomes 1 and `rx_data` takes the new character. `overrun` is cleared only by `ovr_clr` or by reset.
- R10: When the holding buffer is full as a character finishes, the next character starts on the same edge, and `busy` does not drop between the two characters.
- R11: While `master_en`=0 no character starts, and a queued character waits in the holding buffer. Clearing `master_en` during a character aborts it on the next edge (`busy`=0, `sclk`=0), and nothing is delivered to the receive buffer.
- R12: Without a write, the block never toggles `sclk` and never sets `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master operation enable; 0 holds the link idle |
| len8 | input | 1 | Character length select: 1 = 8 bits, 0 = 7 bits |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_valid | input | 1 | Write request for the holding buffer |
| tx_data | input | DW | Character to send |
| tx_ready | output | 1 | Holding buffer empty (transmit-empty flag) |
| rx_valid | output | 1 | Receive buffer holds an unread character |
| rx_data | output | DW | Received character, right-justified |
| rx_ready | input | 1 | Host reads the receive buffer |
| overrun | output | 1 | Sticky overrun error flag |
| busy | output | 1 | A character is on the wire |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |

## Verification
The bench goes after the 7-bit case. A design that left-justified the short character or sent its bit 7 would fail both the serial capture and the receive compare. It also changes `len8` in the middle of a character, which catches a design that reads the pin live instead of latching it at start.

Back-to-back characters are checked for a zero idle gap and for an early return of `tx_ready`. A design that freed the holding buffer only at the end of a character, or that inserted an idle period between characters, would fail there.

The overrun sequence checks three things: that the flag stays set until `ovr_clr`, that the newest character wins, and that clearing the flag leaves the buffered data alone. Disable and abort sequences confirm that `sclk` stays low and that no partial character appears in the receive buffer.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;

  typedef enum logic {
    CHAR_SHORT = 1'b0,
    CHAR_FULL  = 1'b1
  } char_len_e;

  // Index of the final bit of a character, counted from zero.
  function automatic int unsigned last_bit_idx(input char_len_e len, input int unsigned dw);
    return (len == CHAR_FULL) ? dw - 1 : dw - 2;
  endfunction

endpackage

// File: rtl/spi_phase_gen.sv
`timescale 1ns/1ps
module spi_phase_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic sample,
  output logic bit_end
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Low half first, high half second: data launches at the period start,
  // the edge into the high half is the mid-period capture point.
  assign sclk    = run && (cnt >= CW'(HALF));
  assign sample  = run && (cnt == CW'(HALF - 1));
  assign bit_end = run && (cnt == CW'(DIV - 1));

endmodule

// File: rtl/spi_tx_hold.sv
`timescale 1ns/1ps
module spi_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          take,
  output logic          hold_full,
  output logic [DW-1:0] hold_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (wr_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  assign wr_ready = !hold_full;

endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core
  import spi_xfer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          len8,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          sample,
  input  logic          bit_end,
  input  logic          miso,
  output logic          take,
  output logic          active,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] done_data
);
  localparam int BW = $clog2(DW + 1);

  char_len_e     len_sel;
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic [BW-1:0] bcnt;
  logic [BW-1:0] last_idx;
  logic          is_last;
  logic          start;
  logic [DW-1:0] load_word;

  assign len_sel = char_len_e'(len8);
  assign is_last = (bcnt == last_idx);
  assign done    = active && en && bit_end && is_last;
  // Start from idle, or chain straight on from a finishing character.
  assign start   = en && hold_full && (!active || done);
  assign take    = start;

  // Align the character's top bit with the shift-out position.
  assign load_word = (len_sel == CHAR_FULL) ? hold_data : {hold_data[DW-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bcnt     <= '0;
      last_idx <= '0;
    end else if (!en) begin
      active <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      tx_sh    <= load_word;
      rx_sh    <= '0;
      bcnt     <= '0;
      last_idx <= BW'(last_bit_idx(len_sel, DW));
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      if (sample) begin
        rx_sh <= {rx_sh[DW-2:0], miso};
      end
      if (bit_end) begin
        bcnt  <= bcnt + 1'b1;
        tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  assign mosi      = active && tx_sh[DW-1];
  assign done_data = rx_sh;

endmodule

// File: rtl/spi_rx_hold.sv
`timescale 1ns/1ps
module spi_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] done_data,
  input  logic          rd_ready,
  input  logic          ovr_clr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          overrun
);
  logic lost;

  assign lost = done && rd_valid && !rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (done) begin
      rd_valid <= 1'b1;
      rd_data  <= done_data;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
    end else if (lost) begin
      overrun <= 1'b1;
    end else if (ovr_clr) begin
      overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_xfer_master.sv
`timescale 1ns/1ps
module spi_xfer_master #(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_en,
  input  logic          len8,
  input  logic          ovr_clr,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          overrun,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          take;
  logic          core_active;
  logic          core_done;
  logic [DW-1:0] core_data;
  logic          sample;
  logic          bit_end;

  spi_tx_hold #(.DW(DW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (tx_valid),
    .wr_data   (tx_data),
    .wr_ready  (tx_ready),
    .take      (take),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  spi_phase_gen #(.DIV(DIV)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (core_active),
    .sclk    (sclk),
    .sample  (sample),
    .bit_end (bit_end)
  );

  spi_shift_core #(.DW(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (master_en),
    .len8      (len8),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .sample    (sample),
    .bit_end   (bit_end),
    .miso      (miso),
    .take      (take),
    .active    (core_active),
    .mosi      (mosi),
    .done      (core_done),
    .done_data (core_data)
  );

  spi_rx_hold #(.DW(DW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (core_done),
    .done_data (core_data),
    .rd_ready  (rx_ready),
    .ovr_clr   (ovr_clr),
    .rd_valid  (rx_valid),
    .rd_data   (rx_data),
    .overrun   (overrun)
  );

  assign busy = core_active;

endmodule

// File: rtl/spi_xfer_master_chk.sv
`timescale 1ns/1ps
module spi_xfer_master_chk (
  input logic clk,
  input logic rst_n,
  input logic master_en,
  input logic ovr_clr,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic overrun,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic core_done
);
  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r4_mosi_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> (!sclk || $stable(mosi)));

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r7_done_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> rx_valid);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !core_done) |=> !rx_valid);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  a_r11_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !busy);

endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .master_en (master_en),
  .ovr_clr   (ovr_clr),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .overrun   (overrun),
  .busy      (busy),
  .sclk      (sclk),
  .mosi      (mosi),
  .core_done (core_done)
);

// File: tb/tb_spi_xfer_master.sv
`timescale 1ns/1ps
module tb_spi_xfer_master;
  localparam int DW  = 8;
  localparam int DIV = 4;

  typedef struct packed {
    logic       l8;
    logic [7:0] tx;
    logic [7:0] resp;
  } sl_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b1;
  logic len8 = 1'b1;
  logic ovr_clr = 1'b0;
  logic tx_valid = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_ready;
  logic rx_valid;
  logic [DW-1:0] rx_data;
  logic rx_ready;
  logic overrun;
  logic busy;
  logic sclk;
  logic mosi;
  logic miso = 1'b0;
  logic mon_on = 1'b0;
  logic man_rd = 1'b0;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  sl_item_t sq[$];
  logic [7:0] eq[$];

  assign rx_ready = mon_on | man_rd;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_xfer_master #(.DW(DW), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .len8(len8),
    .ovr_clr(ovr_clr), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .overrun(overrun), .busy(busy), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: queue the slave item and the expected receive value, then write.
  task automatic send(input logic [7:0] d, input logic [7:0] resp, input logic l8,
                      input bit to_slave, input bit to_sb);
    sl_item_t it;
    it.l8 = l8; it.tx = d; it.resp = resp;
    if (to_slave) sq.push_back(it);
    if (to_sb) eq.push_back(l8 ? resp : {1'b0, resp[6:0]});
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    while (eq.size() != 0 || busy || !tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Slave model: presents response bits MSB first, captures mosi on sclk rise (R5).
  initial begin
    forever begin
      sl_item_t cur;
      int n;
      logic [7:0] got;
      wait (sq.size() > 0);
      cur = sq.pop_front();
      n = cur.l8 ? 8 : 7;
      got = '0;
      miso = cur.resp[n-1];
      for (int i = 0; i < n; i++) begin
        @(posedge sclk);
        got = {got[6:0], mosi};
        if (i < n - 1) miso = cur.resp[n-2-i];
      end
      // R4 / R6: serial output MSB first, n bits of tx_data
      chk(got == (cur.l8 ? cur.tx : {1'b0, cur.tx[6:0]}), "R4 mosi bits",
          32'(got), 32'(cur.l8 ? cur.tx : {1'b0, cur.tx[6:0]}));
    end
  end

  // Monitor: pops the scoreboard on each handshake (R7, R8).
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rx_valid && rx_ready) begin
        if (eq.size() == 0) begin
          chk(1'b0, "R12 unexpected rx", 32'(rx_data), 32'hffff);
        end else begin
          logic [7:0] e;
          e = eq.pop_front();
          chk(rx_data == e, "R7 rx_data", 32'(rx_data), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t0;
    int hi;
    int gaps;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_ready && !rx_valid && !overrun && !busy && !sclk && !mosi, "R1 reset",
        {26'd0, tx_ready, rx_valid, overrun, busy, sclk, mosi}, 32'h20);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 idle without writes
    hi = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sclk || rx_valid) hi++;
    end
    chk(hi == 0, "R12 no clock without write", 32'(hi), 32'd0);

    // Main function, 8-bit patterns through the scoreboard
    mon_on = 1'b1;
    send(8'hA5, 8'h3C, 1'b1, 1'b1, 1'b1); drain();
    send(8'hFF, 8'h00, 1'b1, 1'b1, 1'b1); drain();
    send(8'h00, 8'hFF, 1'b1, 1'b1, 1'b1); drain();
    send(8'h81, 8'h7E, 1'b1, 1'b1, 1'b1); drain();

    // R3 period and high time
    send(8'h5A, 8'hC3, 1'b1, 1'b1, 1'b1);
    @(posedge sclk); t0 = cyc;
    @(posedge sclk);
    chk(cyc - t0 == DIV, "R3 sclk period", 32'(cyc - t0), 32'(DIV));
    hi = 0;
    @(negedge clk);
    while (sclk) begin hi++; @(negedge clk); end
    chk(hi == DIV / 2, "R3 sclk high time", 32'(hi), 32'(DIV / 2));
    drain();

    // R6 / R7: 7-bit character, right-justified, len8 changed mid-character
    len8 = 1'b0;
    send(8'hD5, 8'hB7, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk(busy, "R6 started", 32'(busy), 32'd1);
    len8 = 1'b1;
    drain();
    len8 = 1'b0;
    send(8'h2A, 8'hFF, 1'b0, 1'b1, 1'b1); drain();
    len8 = 1'b1;

    // R2 / R10: early tx_ready and gapless back-to-back
    send(8'h96, 8'h69, 1'b1, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    chk(busy && tx_ready, "R2 tx_ready while shifting", {30'd0, busy, tx_ready}, 32'h3);
    send(8'h1E, 8'hE1, 1'b1, 1'b1, 1'b1);
    gaps = 0;
    while (eq.size() > 1) begin
      @(negedge clk);
      if (!busy) gaps++;
    end
    chk(gaps == 0, "R10 no idle gap", 32'(gaps), 32'd0);
    drain();

    // R9 overrun: newest wins, sticky until ovr_clr
    mon_on = 1'b0;
    send(8'h11, 8'h4B, 1'b1, 1'b1, 1'b0);
    wait (rx_valid); @(negedge clk);
    chk(!overrun, "R9 no overrun yet", 32'(overrun), 32'd0);
    send(8'h22, 8'hD2, 1'b1, 1'b1, 1'b0);
    wait (busy); wait (!busy); @(negedge clk);
    chk(overrun, "R9 overrun set", 32'(overrun), 32'd1);
    chk(rx_data == 8'hD2, "R9 overwrite", 32'(rx_data), 32'hD2);
    repeat (10) @(negedge clk);
    chk(overrun, "R9 overrun sticky", 32'(overrun), 32'd1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk(!overrun && rx_valid, "R9 cleared by ovr_clr", {30'd0, overrun, rx_valid}, 32'h1);
    man_rd = 1'b1; @(negedge clk); man_rd = 1'b0;
    chk(!rx_valid, "R8 read clears rx_valid", 32'(rx_valid), 32'd0);

    // R11 disabled: character waits in the holding buffer
    mon_on = 1'b1;
    master_en = 1'b0;
    send(8'hC6, 8'h5D, 1'b1, 1'b1, 1'b1);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk || busy || tx_ready) hi++;
    end
    chk(hi == 0, "R11 held while disabled", 32'(hi), 32'd0);
    master_en = 1'b1;
    drain();

    // R11 abort mid-character
    send(8'hF0, 8'h00, 1'b1, 1'b0, 1'b0);
    @(posedge sclk); @(posedge sclk);
    @(negedge clk);
    master_en = 1'b0;
    @(negedge clk);
    chk(!busy && !sclk && !mosi, "R11 abort", {29'd0, busy, sclk, mosi}, 32'd0);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rx_valid || sclk) hi++;
    end
    chk(hi == 0, "R11 nothing delivered", 32'(hi), 32'd0);
    master_en = 1'b1;

    // One more after re-enable
    send(8'h3B, 8'hA4, 1'b1, 1'b1, 1'b1); drain();
    chk(eq.size() == 0, "R7 scoreboard empty", 32'(eq.size()), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule